// File: doc/BRIEF.md
# Exponential-Pitch Audio Oscillator Core

This block is a numerically controlled audio oscillator meant to run at a sample rate of several megahertz, nominally 16 million samples per second, set by a one-cycle `sample_en` strobe. A 12-bit pitch code on a volt-per-octave scale, plus a three-way range choice, is turned into a phase increment. The conversion splits the code into an octave count and a fraction within the octave. The fraction addresses a 2^x table, and the octave count shifts the table value. A 32-bit phase accumulator integrates the increment.

From the phase the block derives three naive waveforms: a sawtooth, a pulse whose width follows a control value, and a sine read from a quarter-wave table. Each of two output channels picks its own waveform. A rising edge on the sync input restarts the cycle. Conversion to a bitstream and analog filtering happen downstream.

Top module: `nco_osc_top`

## Requirements
- R1: While `rst` is high, at the next clock edge both outputs become 0 and the phase becomes 0.
- R2: Let e be the extended pitch code, f = e mod 512 and oct = e / 512. The increment is (M(f) shifted left by oct) shifted right by 15, kept to 32 bits, where M(f) = round(32768 * 2^(f/512)). Raising the code by 512 therefore doubles the increment.
- R3: e = pitch_code + 512*7*r, where r is 0 for range_sel 0, 1 for range_sel 1, and 2 for range_sel 2. A range_sel of 3 acts as 2.
- R4: On each `sample_en` strobe without a sync clear, the phase advances by the increment computed from the pitch and range sampled at the previous strobe. Wrap is modulo 2^32.
- R5: The outputs change only on clock edges where `sample_en` is high. Between strobes they hold, even if the pitch, width, select or sync inputs change.
- R6: The sawtooth sample is phase[31:16] with bit 15 inverted, read as signed. An output shows the phase held after strobe n at strobe n+2.
- R7: The pulse sample is +32767 while phase[31:20] < pulse_width and -32768 otherwise. A width of 0 gives a constant low.
- R8: The sine sample uses k = phase[31:22], quadrant q = k[9:8] and index i = k[7:0], mirrored to 255-i when q[0] is 1. Its magnitude is round(32767*sin((i+0.5)*pi/512)), and it is negated when q[1] is 1.
- R9: Each channel's select code picks 0 sine, 1 sawtooth, 2 pulse, 3 silence (0). The two channels choose independently.
- R10: A rising edge of `sync_in` is held pending. The next strobe (the same one if they coincide) loads the phase with 0 instead of adding the increment. A sync level held high clears only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | One-cycle sample strobe |
| pitch_code | input | 12 | Volt-per-octave pitch code, 512 codes per octave |
| range_sel | input | 2 | Frequency range choice |
| pulse_width | input | 12 | Pulse width threshold |
| sync_in | input | 1 | Phase restart, rising-edge sensitive |
| sel_a | input | 2 | Waveform select, channel A |
| sel_b | input | 2 | Waveform select, channel B |
| out_a | output | 16 | Signed sample, channel A |
| out_b | output | 16 | Signed sample, channel B |

## Verification
The bench restarts the phase with sync and follows the sawtooth sample by sample against an exact phase model. Codes one octave apart and all four range values are covered, so an off-by-one in the latency, a wrong octave offset or a table rounding slip shows up as a wrong ramp value. Pulse and sine are compared against the sawtooth on the other channel across a full cycle. A comparison with the wrong sense or a missing quadrant mirror would flip samples at the edges, and the zero-width case must stay low throughout. Sync held high must not keep clearing the phase, and inputs changed between strobes must leave the outputs untouched.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    WAVE_SINE  = 2'd0,
    WAVE_SAW   = 2'd1,
    WAVE_PULSE = 2'd2,
    WAVE_MUTE  = 2'd3
  } wave_sel_e;

  // mantissa of 2^(f / 2^frac_w), scaled by 2^(mant_w-1)
  function automatic int exp_mant(int f, int frac_w, int mant_w);
    real x;
    x = 2.0 ** (real'(f) / real'(1 << frac_w));
    return $rtoi(x * real'(1 << (mant_w - 1)) + 0.5);
  endfunction

  // quarter-wave magnitude, half-step offset so mirroring is exact
  function automatic int sine_mag(int i, int aw, int amp);
    real a;
    a = (real'(i) + 0.5) * 3.14159265358979 / real'(2 << aw);
    return $rtoi(real'(amp) * $sin(a) + 0.5);
  endfunction

endpackage

// File: rtl/nco_exp_conv.sv
module nco_exp_conv #(
  parameter int PITCH_W   = 12,
  parameter int FRAC_W    = 9,
  parameter int MANT_W    = 16,
  parameter int PHASE_W   = 32,
  parameter int RANGE_OCT = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  logic [PITCH_W-1:0] pitch,
  input  logic [1:0]         range_sel,
  output logic [PHASE_W-1:0] inc
);
  localparam int EXT_W  = PITCH_W + 2;
  localparam int OCT_W  = EXT_W - FRAC_W;
  localparam int DEPTH  = 1 << FRAC_W;
  localparam int SHW    = MANT_W + PHASE_W - 1;
  localparam logic [EXT_W-1:0] STEP = EXT_W'(RANGE_OCT * DEPTH);

  logic [MANT_W-1:0] exp_rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      exp_rom[i] = MANT_W'(nco_pkg::exp_mant(i, FRAC_W, MANT_W));
  end

  logic [EXT_W-1:0] offset;
  logic [EXT_W-1:0] ext_code;

  always_comb begin
    case (range_sel)
      2'd0:    offset = '0;
      2'd1:    offset = STEP;
      default: offset = STEP + STEP;
    endcase
    ext_code = EXT_W'(pitch) + offset;
  end

  logic [MANT_W-1:0] mant_q;
  logic [OCT_W-1:0]  oct_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mant_q <= '0;
      oct_q  <= '0;
    end else if (ce) begin
      mant_q <= exp_rom[ext_code[FRAC_W-1:0]];
      oct_q  <= ext_code[EXT_W-1:FRAC_W];
    end
  end

  assign inc = PHASE_W'((SHW'(mant_q) << oct_q) >> (MANT_W - 1));

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce,
  input  logic               sync_in,
  input  logic [PHASE_W-1:0] inc,
  output logic [PHASE_W-1:0] phase,
  output logic               sync_clr
);
  logic sync_prev;
  logic pend;
  logic rise;

  assign rise     = sync_in & ~sync_prev;
  assign sync_clr = ce & (pend | rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_prev <= 1'b0;
      pend      <= 1'b0;
      phase     <= '0;
    end else begin
      sync_prev <= sync_in;
      pend      <= (pend | rise) & ~ce;
      if (ce)
        phase <= sync_clr ? '0 : phase + inc;
    end
  end

endmodule

// File: rtl/nco_shaper.sv
module nco_shaper #(
  parameter int TOP_W  = 16,
  parameter int PW_W   = 12,
  parameter int SIN_AW = 8,
  parameter int OUT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ce,
  input  logic [TOP_W-1:0]        phase_top,
  input  logic [PW_W-1:0]         width,
  output logic signed [OUT_W-1:0] saw,
  output logic signed [OUT_W-1:0] pulse,
  output logic signed [OUT_W-1:0] sine
);
  localparam int QDEPTH = 1 << SIN_AW;
  localparam int MAG_W  = OUT_W - 1;
  localparam int AMP    = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] sin_rom [QDEPTH];

  initial begin
    for (int i = 0; i < QDEPTH; i++)
      sin_rom[i] = MAG_W'(nco_pkg::sine_mag(i, SIN_AW, AMP));
  end

  logic [1:0]        quad;
  logic [SIN_AW-1:0] idx;
  logic [SIN_AW-1:0] addr;

  assign quad = phase_top[TOP_W-1 -: 2];
  assign idx  = phase_top[TOP_W-3 -: SIN_AW];
  assign addr = quad[0] ? ~idx : idx;

  logic [MAG_W-1:0] mag_q;
  logic             neg_q;
  logic [TOP_W-1:0] saw_q;
  logic             high_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q  <= '0;
      neg_q  <= 1'b0;
      saw_q  <= '0;
      high_q <= 1'b0;
    end else if (ce) begin
      mag_q  <= sin_rom[addr];
      neg_q  <= quad[1];
      saw_q  <= {~phase_top[TOP_W-1], phase_top[TOP_W-2:0]};
      high_q <= phase_top[TOP_W-1 -: PW_W] < width;
    end
  end

  assign saw   = OUT_W'(signed'(saw_q)) <<< (OUT_W - TOP_W);
  assign pulse = high_q ? OUT_W'(AMP) : OUT_W'(-AMP - 1);
  assign sine  = neg_q ? -signed'({1'b0, mag_q}) : signed'({1'b0, mag_q});

endmodule

// File: rtl/nco_osc_top.sv
module nco_osc_top #(
  parameter int PITCH_W   = 12,
  parameter int FRAC_W    = 9,
  parameter int MANT_W    = 16,
  parameter int PHASE_W   = 32,
  parameter int RANGE_OCT = 7,
  parameter int PW_W      = 12,
  parameter int SIN_AW    = 8,
  parameter int OUT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sample_en,
  input  logic [PITCH_W-1:0]      pitch_code,
  input  logic [1:0]              range_sel,
  input  logic [PW_W-1:0]         pulse_width,
  input  logic                    sync_in,
  input  logic [1:0]              sel_a,
  input  logic [1:0]              sel_b,
  output logic signed [OUT_W-1:0] out_a,
  output logic signed [OUT_W-1:0] out_b
);
  import nco_pkg::*;

  localparam int TOP_W = 16;
  localparam int NCH   = 2;

  logic [PHASE_W-1:0] inc;
  logic [PHASE_W-1:0] phase;
  logic               sync_clr;
  logic signed [OUT_W-1:0] w_saw, w_pulse, w_sine;

  nco_exp_conv #(
    .PITCH_W(PITCH_W), .FRAC_W(FRAC_W), .MANT_W(MANT_W),
    .PHASE_W(PHASE_W), .RANGE_OCT(RANGE_OCT)
  ) u_exp (
    .clk(clk), .rst(rst), .ce(sample_en),
    .pitch(pitch_code), .range_sel(range_sel), .inc(inc)
  );

  nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .ce(sample_en), .sync_in(sync_in),
    .inc(inc), .phase(phase), .sync_clr(sync_clr)
  );

  nco_shaper #(
    .TOP_W(TOP_W), .PW_W(PW_W), .SIN_AW(SIN_AW), .OUT_W(OUT_W)
  ) u_shp (
    .clk(clk), .rst(rst), .ce(sample_en),
    .phase_top(phase[PHASE_W-1 -: TOP_W]), .width(pulse_width),
    .saw(w_saw), .pulse(w_pulse), .sine(w_sine)
  );

  logic [1:0]              ch_sel [NCH];
  logic signed [OUT_W-1:0] ch_out [NCH];

  assign ch_sel[0] = sel_a;
  assign ch_sel[1] = sel_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)
        ch_out[c] <= '0;
      else if (sample_en) begin
        case (wave_sel_e'(ch_sel[c]))
          WAVE_SINE:  ch_out[c] <= w_sine;
          WAVE_SAW:   ch_out[c] <= w_saw;
          WAVE_PULSE: ch_out[c] <= w_pulse;
          default:    ch_out[c] <= '0;
        endcase
      end
    end
  end

  assign out_a = ch_out[0];
  assign out_b = ch_out[1];

endmodule

// File: rtl/nco_osc_chk.sv
module nco_osc_chk #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    ce,
  input logic                    sync_clr,
  input logic [PHASE_W-1:0]      phase,
  input logic [PHASE_W-1:0]      inc,
  input logic [1:0]              sel_a,
  input logic [1:0]              sel_b,
  input logic signed [OUT_W-1:0] out_a,
  input logic signed [OUT_W-1:0] out_b
);
  localparam logic signed [OUT_W-1:0] HI = OUT_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [OUT_W-1:0] LO = ~HI;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (out_a == '0 && out_b == '0 && phase == '0));

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && !sync_clr) |=> phase == $past(phase) + $past(inc));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(out_a) && $stable(out_b)));

  assert_pulse_a_R7: assert property (@(posedge clk) disable iff (rst)
    (ce && sel_a == 2'd2) |=> (out_a == HI || out_a == LO));

  assert_pulse_b_R7: assert property (@(posedge clk) disable iff (rst)
    (ce && sel_b == 2'd2) |=> (out_b == HI || out_b == LO));

  assert_mute_R9: assert property (@(posedge clk) disable iff (rst)
    (ce && sel_a == 2'd3) |=> out_a == '0);

  assert_sync_clear_R10: assert property (@(posedge clk) disable iff (rst)
    sync_clr |=> phase == '0);

endmodule

bind nco_osc_top nco_osc_chk #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .ce(sample_en), .sync_clr(sync_clr),
  .phase(phase), .inc(inc), .sel_a(sel_a), .sel_b(sel_b),
  .out_a(out_a), .out_b(out_b)
);

// File: tb/sim_nco_osc_top.sv
module sim_nco_osc_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_en = 1'b0;
  logic [11:0] pitch_code = '0;
  logic [1:0]  range_sel = '0;
  logic [11:0] pulse_width = '0;
  logic        sync_in = 1'b0;
  logic [1:0]  sel_a = 2'd1;
  logic [1:0]  sel_b = 2'd1;
  logic signed [15:0] out_a, out_b;

  int total = 0;
  int bad = 0;
  logic [31:0] ph;

  always #2.5 clk = ~clk;

  nco_osc_top u0 (
    .clk(clk), .rst(rst), .sample_en(sample_en), .pitch_code(pitch_code),
    .range_sel(range_sel), .pulse_width(pulse_width), .sync_in(sync_in),
    .sel_a(sel_a), .sel_b(sel_b), .out_a(out_a), .out_b(out_b)
  );

  task automatic check(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick_ce();
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
  endtask

  function automatic logic [31:0] model_inc(int pitch, int rng);
    int r, e, f, oct, m;
    logic [63:0] w;
    r = (rng > 2) ? 2 : rng;
    e = pitch + 512 * 7 * r;
    f = e % 512;
    oct = e / 512;
    m = $rtoi(32768.0 * (2.0 ** (real'(f) / 512.0)) + 0.5);
    w = 64'(m) << oct;
    return 32'(w >> 15);
  endfunction

  function automatic int saw_of(logic [31:0] p);
    return int'(signed'(16'(p[31:16] ^ 16'h8000)));
  endfunction

  function automatic int sine_of(logic [15:0] top);
    logic [9:0] k;
    int i, m;
    k = top[15:6];
    i = k[8] ? 255 - int'(k[7:0]) : int'(k[7:0]);
    m = $rtoi(32767.0 * $sin((real'(i) + 0.5) * 3.14159265358979 / 512.0) + 0.5);
    return k[9] ? -m : m;
  endfunction

  // settle the pitch, restart with sync, reach the first sample of the ramp
  task automatic restart(int pitch, int rng);
    pitch_code = 12'(pitch);
    range_sel = 2'(rng);
    tick_ce();
    tick_ce();
    @(negedge clk) sync_in = 1'b1;
    tick_ce();   // phase cleared
    tick_ce();   // shaper captures zero phase
    tick_ce();   // output shows phase zero
    ph = '0;
  endtask

  task automatic t_reset();
    check("R1 reset out_a", int'(out_a), 0);
    check("R1 reset out_b", int'(out_b), 0);
  endtask

  // R2 R3 R4 R6: sawtooth ramp against exact phase model
  task automatic t_saw(int pitch, int rng, int n, string tag);
    logic [31:0] inc;
    inc = model_inc(pitch, rng);
    sel_a = 2'd1;
    restart(pitch, rng);
    check({tag, " R6 saw start"}, int'(out_a), -32768);
    for (int j = 1; j <= n; j++) begin
      tick_ce();
      ph = ph + inc;
      check({tag, " R6 saw ramp"}, int'(out_a), saw_of(ph));
    end
    @(negedge clk) sync_in = 1'b0;
  endtask

  // R10: sync held high across many strobes clears only once
  task automatic t_sync_level();
    logic [31:0] inc;
    inc = model_inc(3000, 2);
    sel_a = 2'd1;
    restart(3000, 2);
    for (int j = 1; j <= 40; j++) begin
      tick_ce();
      ph = ph + inc;
    end
    check("R10 sync level no reclear", int'(out_a), saw_of(ph));
    @(negedge clk) sync_in = 1'b0;
    tick_ce();
    @(negedge clk) sync_in = 1'b1;  // new edge, between strobes
    @(negedge clk);
    @(negedge clk) sync_in = 1'b0;  // gone before the strobe, still pending
    tick_ce();
    ph = ph + inc;                  // output at this strobe: still old ramp
    tick_ce();
    tick_ce();
    check("R10 pending edge clears", int'(out_a), -32768);
  endtask

  // R7: pulse on channel B against saw on channel A
  task automatic t_pulse(int pw, int n);
    int top12, exp;
    sel_a = 2'd1;
    sel_b = 2'd2;
    pulse_width = 12'(pw);
    restart(4000, 2);
    @(negedge clk) sync_in = 1'b0;
    for (int j = 0; j < n; j++) begin
      top12 = (int'(out_a) + 32768) >> 4;
      exp = (top12 < pw) ? 32767 : -32768;
      check("R7 pulse", int'(out_b), exp);
      tick_ce();
    end
  endtask

  // R8: sine on channel B against saw on channel A, full cycle
  task automatic t_sine(int n);
    logic [15:0] top;
    sel_a = 2'd1;
    sel_b = 2'd0;
    restart(4000, 2);
    @(negedge clk) sync_in = 1'b0;
    for (int j = 0; j < n; j++) begin
      top = 16'(int'(out_a) + 32768);
      check("R8 sine", int'(out_b), sine_of(top));
      tick_ce();
    end
  endtask

  // R9: mute code and independent selection
  task automatic t_mute();
    sel_a = 2'd3;
    sel_b = 2'd2;
    pulse_width = 12'd4095;
    tick_ce();
    tick_ce();
    check("R9 mute a", int'(out_a), 0);
    check("R9 b independent", (out_b == 16'sd32767 || out_b == -16'sd32768) ? 1 : 0, 1);
  endtask

  // R5: no strobe, inputs change, outputs hold
  task automatic t_hold();
    logic signed [15:0] a0, b0;
    sel_a = 2'd1;
    sel_b = 2'd0;
    tick_ce();
    tick_ce();
    a0 = out_a;
    b0 = out_b;
    @(negedge clk);
    pitch_code = 12'd17;
    range_sel = 2'd0;
    sel_a = 2'd3;
    sel_b = 2'd3;
    pulse_width = 12'd0;
    sync_in = 1'b1;
    repeat (12) @(negedge clk);
    check("R5 hold a", int'(out_a), int'(a0));
    check("R5 hold b", int'(out_b), int'(b0));
    sync_in = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_saw(2000, 2, 30, "R2 R3 R4 base");
    t_saw(2512, 2, 30, "R2 octave up");
    t_saw(1000, 1, 30, "R3 range1");
    t_saw(1000, 3, 30, "R3 range3 as 2");
    t_saw(4095, 0, 10, "R2 top of range0");
    t_saw(3500, 2, 2000, "R4 wrap");
    t_sync_level();
    t_pulse(2048, 1200);
    t_pulse(0, 200);
    t_pulse(4095, 1200);
    t_sine(1200);
    t_mute();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule